// File: doc/BRIEF.md
# Bus Ordering Barrier Controller

This block sits between one bus master's request queue and the shared bus arbiter. It enforces an ordering barrier. Once a barrier command is taken from the queue, no later data transaction is passed to the arbiter until every data transaction granted before the barrier has signalled completion at its destination. The block counts outstanding data transactions. The count rises on each granted data address tenure and falls on each completion pulse from downstream. Instruction fetches pass straight through in both directions and are never counted.

The barrier command is handled locally and never reaches the bus. A compile-time parameter picks one of two enforcement styles. In the hold-grant style, the barrier completes at once and later data requests are masked until the count drains. In the hold-done style, the barrier's own completion is withheld until the count drains, in the way a full synchronisation command behaves, and no second barrier is accepted until then.

Top module: `bus_order_barrier`

## Requirements
- R1: After reset `barrier_busy` and `barrier_done` are low, the outstanding count is zero, and `bus_req` stays low while `req_valid` is low.
- R2: A data request (`req_kind` 2'b00, or the reserved code 2'b11 treated as data) drives `bus_req` in the same cycle when the block is not busy and the count is below its maximum. `req_ready` is `bus_req && bus_gnt` for such a request, and a barrier (2'b10) never raises `bus_req`.
- R3: A fetch request (`req_kind` 2'b01) always drives `bus_req`, also while a barrier is pending, and a granted fetch never changes the outstanding count.
- R4: A barrier accepted while data transactions are outstanding raises `barrier_busy` in the next cycle. `barrier_busy` stays high until the cycle after the count reaches zero, and data requests are blocked for that whole time.
- R5: A barrier accepted when the count, including this cycle's grant and completion, is zero pulses `barrier_done` for one cycle in the next cycle, and `barrier_busy` stays low.
- R6: A data grant and a completion pulse in the same cycle leave the count unchanged.
- R7: At the maximum count (2^CNT_W-1) data requests are blocked. A completion pulse at count zero is ignored.
- R8: In the hold-grant style a barrier is accepted whenever presented, `barrier_done` pulses in the cycle after acceptance, and a barrier arriving while busy merges into the pending wait.
- R9: In the hold-done style a barrier is not accepted while `barrier_busy` is high, and `barrier_done` pulses in the cycle after the count drains.
- R10: Back-to-back barriers with nothing outstanding each complete in the next cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Head of master queue holds a request |
| req_kind | input | 2 | 00 data, 01 fetch, 10 barrier, 11 treated as data |
| req_ready | output | 1 | Head request accepted this cycle |
| bus_req | output | 1 | Request forwarded to the arbiter |
| bus_gnt | input | 1 | Arbiter grant; a tenure is taken when `bus_req && bus_gnt` |
| cpl_pulse | input | 1 | One data transaction completed at its destination |
| barrier_busy | output | 1 | A barrier is waiting for earlier transactions |
| barrier_done | output | 1 | One-cycle barrier completion |

## Verification
The in-RTL assertions check the per-cycle rules on every cycle. These are the masking of data while busy, fetch pass-through, a barrier never on the bus, the count holding on simultaneous grant and completion, the saturation limits, and each style's acceptance and completion timing. Only the bench's scenarios can show the whole sequences: the exact length of a busy window while completions arrive, merged barriers in the hold-grant style, refused barriers in the hold-done style, and draining from a full counter. For these the bench's cycle-by-cycle model runs both styles against the same stimulus.

// File: rtl/obc_pkg.sv
// Shared request encodings and the enforcement-style selector.
package obc_pkg;
    typedef enum logic [1:0] {
        KIND_DATA    = 2'b00,
        KIND_FETCH   = 2'b01,
        KIND_BARRIER = 2'b10,
        KIND_RSVD    = 2'b11
    } req_kind_e;

    typedef enum logic {
        STYLE_HOLD_GRANT = 1'b0,
        STYLE_HOLD_DONE  = 1'b1
    } style_e;
endpackage

// File: rtl/obc_outstanding_ctr.sv
// Outstanding data-transaction counter.
// Counts granted data tenures minus completion pulses. It never wraps: an
// increment at the maximum is assumed blocked upstream and is dropped here,
// and a decrement at zero is ignored. Provides the next-cycle zero flag.
module obc_outstanding_ctr #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic zero_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // Next count: simultaneous inc and dec cancel; saturate at both ends.
    always_comb begin
        count_d = count_q;
        if (inc && !dec && count_q != CNT_MAX) begin
            count_d = count_q + 1'b1;
        end else if (dec && !inc && count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign full      = (count_q == CNT_MAX);
    assign zero_next = (count_d == '0);

    AST_INC_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> (count_q == $past(count_q))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !inc); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && dec && !inc) |=> (count_q == '0)); // R7
endmodule

// File: rtl/obc_issue_gate.sv
// Request gating between the master queue and the arbiter.
// Decodes the head request kind, masks data while a barrier waits or the
// counter is full, lets fetches through and consumes barriers locally.
// Assumes one request at the head per cycle.
module obc_issue_gate
    import obc_pkg::*;
#(
    parameter style_e STYLE = STYLE_HOLD_GRANT
) (
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       busy,
    input  logic       full,
    input  logic       bus_gnt,
    output logic       bus_req,
    output logic       req_ready,
    output logic       data_acc,
    output logic       bar_acc,
    output logic       is_fetch
);
    logic is_bar;
    logic is_data;
    logic bar_ready;

    // Kind decode: anything not fetch or barrier is ordered as data.
    always_comb begin
        is_fetch = (req_kind == KIND_FETCH);
        is_bar   = (req_kind == KIND_BARRIER);
        is_data  = !is_fetch && !is_bar;
    end

    // Barrier acceptance rule picked by the enforcement style.
    if (STYLE == STYLE_HOLD_GRANT) begin : g_bar_grant
        assign bar_ready = 1'b1;
    end else begin : g_bar_done
        assign bar_ready = !busy;
    end

    // Forwarding and handshake back to the queue.
    always_comb begin
        bus_req   = req_valid && (is_fetch || (is_data && !busy && !full));
        data_acc  = bus_req && bus_gnt && is_data;
        bar_acc   = req_valid && is_bar && bar_ready;
        req_ready = is_bar ? bar_acc : (bus_req && bus_gnt);
    end
endmodule

// File: rtl/obc_barrier_track.sv
// Barrier wait tracker.
// Holds the busy flag from barrier acceptance until the outstanding count
// drains and produces the one-cycle completion pulse at the point the
// enforcement style defines.
module obc_barrier_track
    import obc_pkg::*;
#(
    parameter style_e STYLE = STYLE_HOLD_GRANT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bar_acc,
    input  logic zero_next,
    output logic busy,
    output logic done
);
    logic busy_q;
    logic busy_d;
    logic done_q;
    logic done_d;
    logic waiting;

    assign waiting = busy_q || bar_acc;

    // Busy holds while a barrier waits and the count is not yet drained.
    always_comb begin
        busy_d = waiting && !zero_next;
    end

    // Completion point per style.
    if (STYLE == STYLE_HOLD_GRANT) begin : g_done_grant
        assign done_d = bar_acc;
    end else begin : g_done_done
        assign done_d = waiting && zero_next;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            busy_q <= busy_d;
            done_q <= done_d;
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    AST_ZERO_CNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_acc && !busy_q && zero_next) |=> (done_q && !busy_q)); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !zero_next) |=> busy_q); // R4

    if (STYLE == STYLE_HOLD_GRANT) begin : g_ast_grant
        AST_GRANT_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            bar_acc |=> done_q); // R8
    end else begin : g_ast_done
        AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q |-> !bar_acc); // R9
    end
endmodule

// File: rtl/bus_order_barrier.sv
// Bus ordering barrier controller (top).
// Sits between one master's request queue and the arbiter. Data tenures
// granted before a barrier must complete before later data tenures are
// forwarded; fetches are exempt. STYLE selects whether the barrier's own
// completion or later grants are withheld. Assumes cpl_pulse fires once per
// completed data transaction and never for fetches.
module bus_order_barrier
    import obc_pkg::*;
#(
    parameter style_e STYLE = STYLE_HOLD_GRANT,
    parameter int     CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       req_ready,
    output logic       bus_req,
    input  logic       bus_gnt,
    input  logic       cpl_pulse,
    output logic       barrier_busy,
    output logic       barrier_done
);
    logic full;
    logic zero_next;
    logic data_acc;
    logic bar_acc;
    logic is_fetch;

    obc_issue_gate #(.STYLE(STYLE)) u_gate (
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .busy      (barrier_busy),
        .full      (full),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .req_ready (req_ready),
        .data_acc  (data_acc),
        .bar_acc   (bar_acc),
        .is_fetch  (is_fetch)
    );

    obc_outstanding_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (data_acc),
        .dec       (cpl_pulse),
        .full      (full),
        .zero_next (zero_next)
    );

    obc_barrier_track #(.STYLE(STYLE)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bar_acc   (bar_acc),
        .zero_next (zero_next),
        .busy      (barrier_busy),
        .done      (barrier_done)
    );

    AST_BUSY_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        barrier_busy |-> !(bus_req && !is_fetch)); // R4
    AST_FETCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_fetch) |-> bus_req); // R3
    AST_BARRIER_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == KIND_BARRIER) |-> !bus_req); // R2
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid); // R2
endmodule

// File: tb/bus_order_barrier_bench.sv
// Bench: drives both enforcement styles with the same stimulus and compares
// each against a behavioural model on every clock.
module bus_order_barrier_bench;
    import obc_pkg::*;

    localparam int CNT_W   = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic       bus_gnt = 1'b0;
    logic       cpl_pulse = 1'b0;
    logic [1:0] w_ready, w_req, w_busy, w_done;

    int errors = 0;
    int checks = 0;
    int m_cnt  [2];
    bit m_busy [2];
    bit m_done [2];

    always #10 clk = ~clk;

    bus_order_barrier #(.STYLE(STYLE_HOLD_GRANT), .CNT_W(CNT_W)) u_bus_order_barrier (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ready(w_ready[0]), .bus_req(w_req[0]), .bus_gnt(bus_gnt),
        .cpl_pulse(cpl_pulse), .barrier_busy(w_busy[0]), .barrier_done(w_done[0]));

    bus_order_barrier #(.STYLE(STYLE_HOLD_DONE), .CNT_W(CNT_W)) u_bus_order_barrier_done (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ready(w_ready[1]), .bus_req(w_req[1]), .bus_gnt(bus_gnt),
        .cpl_pulse(cpl_pulse), .barrier_busy(w_busy[1]), .barrier_done(w_done[1]));

    task automatic chk(input bit act, input bit exp, input string tag,
                       input string what, input int s);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s style%0d %s actual=%0b expected=%0b at %0t",
                     tag, s, what, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare all outputs, then advance the model.
    task automatic step(input bit v, input logic [1:0] k, input bit g,
                        input bit c, input string tag);
        bit is_f, is_b, is_d, e_req, e_rdy, acc, inc, dec, wait_b;
        @(negedge clk);
        req_valid = v; req_kind = k; bus_gnt = g; cpl_pulse = c;
        #1;
        for (int s = 0; s < 2; s++) begin
            is_f  = (k == 2'b01);
            is_b  = (k == 2'b10);
            is_d  = !is_f && !is_b;
            e_req = v && (is_f || (is_d && !m_busy[s] && m_cnt[s] != CNT_MAX));
            acc   = v && is_b && (s == 0 || !m_busy[s]);
            e_rdy = is_b ? acc : (e_req && g);
            chk(w_req[s],   e_req,     tag, "bus_req",      s);
            chk(w_ready[s], e_rdy,     tag, "req_ready",    s);
            chk(w_busy[s],  m_busy[s], tag, "barrier_busy", s);
            chk(w_done[s],  m_done[s], tag, "barrier_done", s);
        end
        @(posedge clk);
        for (int s = 0; s < 2; s++) begin
            is_f   = (k == 2'b01);
            is_b   = (k == 2'b10);
            is_d   = !is_f && !is_b;
            e_req  = v && (is_f || (is_d && !m_busy[s] && m_cnt[s] != CNT_MAX));
            acc    = v && is_b && (s == 0 || !m_busy[s]);
            inc    = e_req && g && is_d;
            dec    = c;
            if (inc && !dec)                  m_cnt[s] = m_cnt[s] + 1;
            else if (dec && !inc && m_cnt[s] > 0) m_cnt[s] = m_cnt[s] - 1;
            wait_b    = m_busy[s] || acc;
            m_done[s] = (s == 0) ? acc : (wait_b && m_cnt[s] == 0);
            m_busy[s] = wait_b && m_cnt[s] != 0;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_cnt[s] = 0; m_busy[s] = 0; m_done[s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle after reset
        repeat (3) step(0, 2'b00, 0, 0, "R1");
        // R5 / R10: barriers with nothing outstanding
        repeat (3) step(1, 2'b10, 0, 0, "R10");
        step(0, 2'b00, 0, 0, "R5");
        // R2: data held without grant, then granted
        step(1, 2'b00, 0, 0, "R2");
        repeat (3) step(1, 2'b00, 1, 0, "R2");
        step(1, 2'b11, 1, 0, "R2");
        // R4 / R8 / R9: barrier with four outstanding
        step(1, 2'b10, 0, 0, "R4");
        step(1, 2'b00, 1, 0, "R4");
        step(1, 2'b01, 1, 0, "R3");
        step(1, 2'b10, 0, 0, "R9");
        step(0, 2'b00, 0, 0, "R8");
        step(0, 2'b00, 0, 1, "R4");
        step(1, 2'b01, 1, 1, "R3");
        step(1, 2'b00, 1, 1, "R4");
        step(0, 2'b00, 0, 1, "R9");
        repeat (2) step(0, 2'b00, 0, 0, "R4");
        step(1, 2'b00, 1, 0, "R2");
        // R6: grant and completion together
        step(1, 2'b00, 1, 1, "R6");
        step(1, 2'b10, 0, 0, "R6");
        step(0, 2'b00, 0, 1, "R6");
        repeat (2) step(0, 2'b00, 0, 0, "R6");
        // R7: fill to the limit, then drain past zero
        repeat (CNT_MAX + 2) step(1, 2'b00, 1, 0, "R7");
        repeat (CNT_MAX + 2) step(0, 2'b00, 0, 1, "R7");
        step(1, 2'b10, 0, 0, "R5");
        step(0, 2'b00, 0, 0, "R5");
        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, 2'($urandom % 4), ($urandom % 3) != 0,
                 ($urandom % 3) == 0, "R2");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule